// File: doc/BRIEF.md
# Framed three-bit pattern detector

This block watches a one-bit serial stream and cuts it into back-to-back groups of three bits. The first bit sampled after reset starts the first group. Groups do not overlap. When the third bit of a group arrives, the block raises a single-cycle flag if the group reads 010 or 110, oldest bit first. Put another way, the flag rises when the middle bit was 1 and the last bit is 0. The first bit of every group is ignored.

The flag is a Mealy output. It is decoded from the stored state and the live input bit, so it is valid in the same cycle that the third bit is presented. The machine is the state-minimized form: four states held in a two-bit register. After the third bit of a group it always returns to its start state. Asserting reset at any point throws away a partial group.

Top module: `triad_detect`

## Requirements
- R1: While `rst_n` is low, `hit` is 0 whatever `din` is, and the group position returns to the first bit.
- R2: Bits are taken one per rising clock edge in consecutive, non-overlapping groups of three. The first bit sampled after `rst_n` rises opens the first group.
- R3: `hit` is 1 in the cycle the third bit of a group is present when that bit is 0 and the second bit was 1. This covers the groups 010 and 110, oldest bit first.
- R4: The first bit of a group has no effect. Groups that differ only in their first bit give identical `hit` values.
- R5: A group whose second bit is 0 never raises `hit`. This covers 000, 001, 100 and 101.
- R6: `hit` is 0 in the cycles that present the first and second bits of a group. It is also 0 in the third-bit cycle when the third bit is 1 (011 and 111).
- R7: A 010 or 110 pattern that straddles a group boundary is not reported.
- R8: Lowering `rst_n` in the middle of a group discards the bits already taken. Counting restarts at the first bit after release.
- R9: The state register steps through four states in a fixed order: start, then first bit taken, then one of two "middle bit" states, then start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `din` is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| din | input | 1 | Serial data bit, one per cycle |
| hit | output | 1 | One-cycle flag for a 010 or 110 group, valid in the third-bit cycle |

## Verification
Every result of this block is due in the same cycle as the bit that causes it, because `hit` is combinational from the stored state and `din`. The driver changes `din` on the falling edge and pushes the expected flag for that bit into the queue. The monitor compares the flag one nanosecond later, well before the next rising edge moves the state. Reset cycles are queued the same way. Release of `rst_n` coincides with driving the first bit of a new group, so the model's group counter and the register restart on the same edge.

// File: rtl/triad_pkg.sv
package triad_pkg;
  localparam int unsigned ST_W = 2;

  // bit 1 set: the middle bit has been taken and bit 0 holds its value
  typedef enum logic [ST_W-1:0] {
    ST_START = 2'b00,
    ST_FIRST = 2'b01,
    ST_MID0  = 2'b10,
    ST_MID1  = 2'b11
  } state_t;
endpackage

// File: rtl/triad_next.sv
module triad_next
  import triad_pkg::*;
(
  input  state_t cur_st,
  input  logic   bit_in,
  output state_t nxt_st
);
  always_comb begin
    nxt_st = ST_START;
    case (cur_st)
      ST_START: nxt_st = ST_FIRST;                      // first bit dropped
      ST_FIRST: nxt_st = bit_in ? ST_MID1 : ST_MID0;    // remember middle bit
      ST_MID0:  nxt_st = ST_START;
      ST_MID1:  nxt_st = ST_START;
      default:  nxt_st = ST_START;
    endcase
  end
endmodule

// File: rtl/triad_state_reg.sv
module triad_state_reg
  import triad_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  state_t nxt_st,
  output state_t cur_st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_st <= ST_START;
    end else if (load_en) begin
      cur_st <= nxt_st;
    end
  end
endmodule

// File: rtl/triad_hit.sv
module triad_hit
  import triad_pkg::*;
(
  input  logic   rst_n,
  input  state_t cur_st,
  input  logic   bit_in,
  output logic   hit_o
);
  logic last_slot;
  logic mid_one;

  always_comb begin
    last_slot = cur_st[1];
    mid_one   = cur_st[0];
    hit_o     = rst_n & last_slot & mid_one & ~bit_in;
  end
endmodule

// File: rtl/triad_detect.sv
module triad_detect
  import triad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit
);
  state_t cur_st;
  state_t nxt_st;
  logic   step_en;

  // a bit is consumed on every edge; the enable is kept explicit
  assign step_en = 1'b1;

  triad_next u_next (
    .cur_st (cur_st),
    .bit_in (din),
    .nxt_st (nxt_st)
  );

  triad_state_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (step_en),
    .nxt_st  (nxt_st),
    .cur_st  (cur_st)
  );

  triad_hit u_hit (
    .rst_n  (rst_n),
    .cur_st (cur_st),
    .bit_in (din),
    .hit_o  (hit)
  );
endmodule

// File: rtl/triad_detect_chk.sv
module triad_detect_chk
  import triad_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       din,
  input logic       hit,
  input logic [1:0] st
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !hit);

  // R4
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START) |=> (st == ST_FIRST));

  // R9
  middle_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FIRST) |=> (st == {1'b1, $past(din)}));

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st[1] |=> (st == ST_START));

  // R3
  hit_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(st) == ST_FIRST) && $past(din));

  // R6
  hit_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (st == ST_START) && !hit);
endmodule

bind triad_detect triad_detect_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .din   (din),
  .hit   (hit),
  .st    (cur_st)
);

// File: tb/tb_triad_detect.sv
`timescale 1ns/1ps
module tb_triad_detect;
  logic clk;
  logic rst_n;
  logic din;
  logic hit;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int    n_vec;
  int    n_bad;
  int    pos;
  logic  mid_bit;
  bit    done;

  triad_detect dut (.clk(clk), .rst_n(rst_n), .din(din), .hit(hit));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // driver: one bit per cycle, expected flag computed from the group model
  task automatic send_bit(input logic b, input string tag);
    item_t it;
    @(negedge clk);
    rst_n = 1'b1;
    din   = b;
    it.exp = (pos == 2) && mid_bit && !b;
    it.tag = tag;
    q.push_back(it);
    if (pos == 1) mid_bit = b;
    pos = (pos == 2) ? 0 : pos + 1;
  endtask

  task automatic send_group(input logic [2:0] g, input string tag);
    send_bit(g[2], tag);
    send_bit(g[1], tag);
    send_bit(g[0], tag);
  endtask

  // reset stays low until the next send_bit releases it with the first bit
  task automatic hold_reset(input int cycles);
    item_t it;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rst_n = 1'b0;
      din   = i[0];
      it.exp = 1'b0;
      it.tag = "R1";
      q.push_back(it);
    end
    pos = 0;
    mid_bit = 1'b0;
  endtask

  // monitor: compare each queued item in its own cycle
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_vec++;
        if (hit !== it.exp) begin
          n_bad++;
          $display("FAIL %s: hit=%b expected %b at %0t", it.tag, hit, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; pos = 0; mid_bit = 1'b0; done = 1'b0;
    rst_n = 1'b0;
    din = 1'b0;
    hold_reset(3);                              // R1 reset state
    // R3: both detecting groups
    send_group(3'b010, "R3");
    send_group(3'b110, "R3");
    // R5: middle bit 0 never detects
    send_group(3'b000, "R5");
    send_group(3'b001, "R5");
    send_group(3'b100, "R5");
    send_group(3'b101, "R5");
    // R6: third bit 1 gives no flag
    send_group(3'b011, "R6");
    send_group(3'b111, "R6");
    // R4: same tail, differing first bit
    send_group(3'b010, "R4");
    send_group(3'b110, "R4");
    send_group(3'b011, "R4");
    // R7: 010 across the boundary (x01 0xx), then 110 (x11 0xx)
    send_group(3'b001, "R7");
    send_group(3'b000, "R7");
    send_group(3'b011, "R7");
    send_group(3'b011, "R7");
    // R2: long alternating stream, groups counted from release
    for (int i = 0; i < 30; i++) send_bit(i[0], "R2");
    // R8: reset after two bits of a group, then restart
    send_bit(1'b0, "R8");
    send_bit(1'b1, "R8");
    hold_reset(2);
    send_group(3'b010, "R8");
    send_bit(1'b1, "R8");
    hold_reset(1);
    send_group(3'b110, "R8");
    // R1: reset during a third-bit cycle that would detect
    send_bit(1'b1, "R1");
    send_bit(1'b1, "R1");
    hold_reset(2);
    send_group(3'b010, "R2");
    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule